// File: doc/BRIEF.md
# Dual-View GPIO Controller with Pin Ownership

This block controls a bank of general-purpose pins (32 by default) with level-sensitive interrupts. Software reaches it through a 32-bit register bus that exposes two windows onto one set of pin state. The privileged window sees and reports every pin. The restricted window sees only the pins that the privileged side has handed to it through an ownership mask. Because both windows address the same storage, moving a pin between windows moves its whole configuration at once, with no copying.

Each pin has an output value, a direction and an enable. It also has an interrupt polarity, an interrupt mask and a sticky interrupt flag. Pin inputs pass through a two-stage synchronizer. A flag is raised while the synchronized pin sits at its programmed level. A write of one clears the flag, but only once the pin has left that level. Two interrupt lines leave the block, one per window, and each collects only the pins that belong to its window.

Each pin's flag is a two-state machine, instantiated once per pin. In `FLG_IDLE` the pin has no pending interrupt. The transition *trigger* (the pin is enabled and its synchronized input equals its level bit) moves it to `FLG_PEND`. The transition *release* (a write-one-to-clear reaches the pin while the trigger condition is false) returns it to `FLG_IDLE`. In `FLG_PEND` the trigger condition blocks release, so the flag cannot be cleared while the pin stays at its level.

Top module: `gpio_dual_view`

## Requirements
- R1: Registers sit at byte offsets that are multiples of four. The restricted window uses 0x00 OUT, 0x04 DIR, 0x08 IN, 0x0C LEVEL, 0x10 FLAG, 0x14 MASK and 0x18 SNAP. The privileged window uses 0x1C ENABLE, 0x20 OUT, 0x24 DIR, 0x28 IN, 0x2C LEVEL, 0x30 FLAG, 0x34 MASK, 0x38 SNAP and 0x3C OWNER. Any other address, including a misaligned one or one at 0x40 or above, reads 0, and writes to it change nothing.
- R2: A pin drives when both its DIR bit and its ENABLE bit are 1, and `pin_oe` shows this. `pin_out` carries the pin's OUT bit on driving pins and is 0 on all other pins.
- R3: IN returns the pin inputs two clock edges after they change. Writes to IN or SNAP are ignored.
- R4: When an enabled pin's synchronized input equals its LEVEL bit (1 means high, 0 means low), its FLAG bit is 1 after the next clock edge and stays 1.
- R5: Writing 1 to a FLAG bit clears it only if the pin no longer matches its level. While the pin still matches, the bit stays 1. Writing 0 has no effect.
- R6: `irq_priv` is the OR of MASK & FLAG & ~OWNER. `irq_restr` is the OR of MASK & FLAG & OWNER.
- R7: In the restricted window, bits whose OWNER bit is 0 read as 0, and writes leave them unchanged.
- R8: The privileged window reads every bit. Its writes to OUT, DIR, LEVEL, MASK and FLAG change only the bits whose OWNER bit is 0. ENABLE and OWNER are written in full.
- R9: Both windows share one storage, so a pin's existing settings appear in the restricted window as soon as its OWNER bit is set.
- R10: A pin whose ENABLE bit is 0 neither drives nor sets its flag.
- R11: SNAP captures the synchronized inputs on each clock edge at which any FLAG bit rises, and holds otherwise.
- R12: After reset, OUT, DIR, MASK, FLAG, OWNER, SNAP and the synchronizer are 0, LEVEL and ENABLE are all ones, and both interrupt lines are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Bus access strobe |
| bus_we | input | 1 | Access is a write when 1 |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| pin_in | input | 32 | Raw pin inputs |
| pin_oe | output | 32 | Per-pin output enable |
| pin_out | output | 32 | Per-pin output value |
| irq_priv | output | 1 | Privileged-window interrupt |
| irq_restr | output | 1 | Restricted-window interrupt |

## Verification
A wrong write mask shows up on the very next read of OUT or MASK. The bench sweeps owner patterns and compares every bit of every read with a model of the masked update. A flag machine stuck in the wrong state shows up at FLAG, SNAP and the interrupt lines three edges after a pin moves. For that reason every pin is driven alone, read, cleared while active and cleared while idle. Misrouted interrupts appear at once when the owner bit of a pending, masked pin is flipped.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
    typedef enum logic [3:0] {
        REG_NONE, REG_OUT, REG_DIR, REG_IN, REG_LVL,
        REG_FLAG, REG_MASK, REG_SNAP, REG_EN, REG_OWN
    } reg_kind_e;

    typedef enum logic {
        FLG_IDLE = 1'b0,
        FLG_PEND = 1'b1
    } flag_state_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < STAGES; k++) stg[k] <= '0;
        end else begin
            stg[0] <= din;
            for (int k = 1; k < STAGES; k++) stg[k] <= stg[k-1];
        end
    end

    assign dout = stg[STAGES-1];
endmodule

// File: rtl/gpio_decode.sv
module gpio_decode
    import gpio_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic [AW-1:0] addr,
    output reg_kind_e     kind,
    output logic          restr
);
    always_comb begin
        kind  = REG_NONE;
        restr = 1'b0;
        if (addr[1:0] == 2'b00 && addr[AW-1:6] == '0) begin
            unique case (addr[5:2])
                4'd0:  begin kind = REG_OUT;  restr = 1'b1; end
                4'd1:  begin kind = REG_DIR;  restr = 1'b1; end
                4'd2:  begin kind = REG_IN;   restr = 1'b1; end
                4'd3:  begin kind = REG_LVL;  restr = 1'b1; end
                4'd4:  begin kind = REG_FLAG; restr = 1'b1; end
                4'd5:  begin kind = REG_MASK; restr = 1'b1; end
                4'd6:  begin kind = REG_SNAP; restr = 1'b1; end
                4'd7:  kind = REG_EN;
                4'd8:  kind = REG_OUT;
                4'd9:  kind = REG_DIR;
                4'd10: kind = REG_IN;
                4'd11: kind = REG_LVL;
                4'd12: kind = REG_FLAG;
                4'd13: kind = REG_MASK;
                4'd14: kind = REG_SNAP;
                4'd15: kind = REG_OWN;
            endcase
        end
    end
endmodule

// File: rtl/gpio_flag_bank.sv
module gpio_flag_bank
    import gpio_pkg::*;
#(
    parameter int PINS = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PINS-1:0] trig,
    input  logic [PINS-1:0] clr,
    output logic [PINS-1:0] flag,
    output logic            any_rise
);
    logic [PINS-1:0] rise_v;

    for (genvar i = 0; i < PINS; i++) begin : g_pin
        flag_state_e st_q, st_d;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) st_q <= FLG_IDLE;
            else        st_q <= st_d;
        end

        always_comb begin
            st_d = st_q;
            unique case (st_q)
                FLG_IDLE: if (trig[i])            st_d = FLG_PEND;
                FLG_PEND: if (clr[i] && !trig[i]) st_d = FLG_IDLE;
            endcase
        end

        assign flag[i]   = (st_q == FLG_PEND);
        assign rise_v[i] = (st_q == FLG_IDLE) && trig[i];

        // R5: a pin still at its level keeps its flag pending
        a_r5_flag_stuck: assert property (@(posedge clk) disable iff (!rst_n)
            trig[i] |=> (st_q == FLG_PEND));
        // R4: a pending flag only leaves through a clear request
        a_r4_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            (st_q == FLG_PEND && !clr[i]) |=> (st_q == FLG_PEND));
    end

    assign any_rise = |rise_v;
endmodule

// File: rtl/gpio_dual_view.sv
module gpio_dual_view
    import gpio_pkg::*;
#(
    parameter int PINS        = 32,
    parameter int DW          = 32,
    parameter int AW          = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bus_sel,
    input  logic            bus_we,
    input  logic [AW-1:0]   bus_addr,
    input  logic [DW-1:0]   bus_wdata,
    output logic [DW-1:0]   bus_rdata,
    input  logic [PINS-1:0] pin_in,
    output logic [PINS-1:0] pin_oe,
    output logic [PINS-1:0] pin_out,
    output logic            irq_priv,
    output logic            irq_restr
);
    localparam logic [PINS-1:0] ALL_ONES = {PINS{1'b1}};

    reg_kind_e       kind;
    logic            restr;
    logic            wr;
    logic [PINS-1:0] wd, wmask, trig, clr, flag, in_s, raw, vis;
    logic [PINS-1:0] out_q, dir_q, lvl_q, mask_q, en_q, own_q, snap_q;
    logic            any_rise;

    function automatic logic [PINS-1:0] merge(input logic [PINS-1:0] old_v,
                                              input logic [PINS-1:0] new_v,
                                              input logic [PINS-1:0] m);
        return (old_v & ~m) | (new_v & m);
    endfunction

    gpio_decode #(.AW(AW)) u_dec (
        .addr  (bus_addr),
        .kind  (kind),
        .restr (restr)
    );

    gpio_sync #(.W(PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (pin_in),
        .dout  (in_s)
    );

    assign wr    = bus_sel && bus_we;
    assign wd    = bus_wdata[PINS-1:0];
    assign wmask = restr ? own_q : ~own_q;
    assign trig  = ~(in_s ^ lvl_q) & en_q;
    assign clr   = (wr && kind == REG_FLAG) ? (wd & wmask) : '0;

    gpio_flag_bank #(.PINS(PINS)) u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .trig     (trig),
        .clr      (clr),
        .flag     (flag),
        .any_rise (any_rise)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q  <= '0;
            dir_q  <= '0;
            lvl_q  <= ALL_ONES;
            mask_q <= '0;
            en_q   <= ALL_ONES;
            own_q  <= '0;
            snap_q <= '0;
        end else begin
            if (any_rise) snap_q <= in_s;
            if (wr) begin
                unique case (kind)
                    REG_OUT:  out_q  <= merge(out_q,  wd, wmask);
                    REG_DIR:  dir_q  <= merge(dir_q,  wd, wmask);
                    REG_LVL:  lvl_q  <= merge(lvl_q,  wd, wmask);
                    REG_MASK: mask_q <= merge(mask_q, wd, wmask);
                    REG_EN:   en_q   <= wd;
                    REG_OWN:  own_q  <= wd;
                    default:  ;
                endcase
            end
        end
    end

    always_comb begin
        unique case (kind)
            REG_OUT:  raw = out_q;
            REG_DIR:  raw = dir_q;
            REG_IN:   raw = in_s;
            REG_LVL:  raw = lvl_q;
            REG_FLAG: raw = flag;
            REG_MASK: raw = mask_q;
            REG_SNAP: raw = snap_q;
            REG_EN:   raw = en_q;
            REG_OWN:  raw = own_q;
            default:  raw = '0;
        endcase
        vis = restr ? (raw & own_q) : raw;
        bus_rdata = '0;
        bus_rdata[PINS-1:0] = vis;
    end

    assign pin_oe    = dir_q & en_q;
    assign pin_out   = out_q & pin_oe;
    assign irq_priv  = |(mask_q & flag & ~own_q);
    assign irq_restr = |(mask_q & flag & own_q);

    // R8: privileged writes leave owned OUT bits alone
    a_r8_priv_skips_owned: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !restr && kind == REG_OUT) |=> (((out_q ^ $past(out_q)) & $past(own_q)) == '0));
    // R7: restricted writes leave unowned DIR bits alone
    a_r7_restr_skips_unowned: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && restr && kind == REG_DIR) |=> (((dir_q ^ $past(dir_q)) & ~$past(own_q)) == '0));
    // R6: the restricted line needs at least one owned pin
    a_r6_restr_needs_owner: assert property (@(posedge clk) disable iff (!rst_n)
        irq_restr |-> (own_q != '0));
    // R11: the snapshot holds unless a flag rises
    a_r11_snap_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !any_rise |=> $stable(snap_q));
    // R3: a write to IN changes no stored register
    a_r3_in_write_inert: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && kind == REG_IN) |=> ($stable(out_q) && $stable(dir_q) && $stable(own_q)));
endmodule

// File: tb/tb_gpio_dual_view.sv
module tb_gpio_dual_view;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic [31:0] pin_in = '0, pin_oe, pin_out;
    logic        irq_priv, irq_restr;
    int          checks = 0, bad = 0;
    bit          finished = 0;

    localparam logic [7:0] R_OUT = 8'h00, R_DIR = 8'h04, R_IN = 8'h08, R_LVL = 8'h0C,
                           R_FLAG = 8'h10, R_MASK = 8'h14, R_SNAP = 8'h18;
    localparam logic [7:0] P_EN = 8'h1C, P_OUT = 8'h20, P_DIR = 8'h24, P_IN = 8'h28,
                           P_LVL = 8'h2C, P_FLAG = 8'h30, P_MASK = 8'h34, P_SNAP = 8'h38,
                           P_OWN = 8'h3C;

    always #10 clk = ~clk;

    gpio_dual_view dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_oe(pin_oe), .pin_out(pin_out),
        .irq_priv(irq_priv), .irq_restr(irq_restr)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bw(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic br(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run;
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [31:0] v, p, q, o, mo;
        idle(2);
        rst_n = 1'b1;
        idle(1);

        // R12 reset values
        br(P_EN, v);   chk("R12 enable", v, 32'hFFFF_FFFF);
        br(P_LVL, v);  chk("R12 level", v, 32'hFFFF_FFFF);
        br(P_OUT, v);  chk("R12 out", v, 0);
        br(P_DIR, v);  chk("R12 dir", v, 0);
        br(P_OWN, v);  chk("R12 owner", v, 0);
        br(P_FLAG, v); chk("R12 flag", v, 0);
        br(P_SNAP, v); chk("R12 snap", v, 0);
        chk("R12 oe", pin_oe, 0);
        chk("R12 irqs", {30'd0, irq_priv, irq_restr}, 0);

        // R2 output drive sweep
        for (int k = 0; k < 12; k++) begin
            p = 32'h9E37_79B9 * (k + 1);
            q = ~p ^ (32'h0101_0101 * k);
            bw(P_DIR, p);
            bw(P_OUT, q);
            idle(1);
            chk("R2 oe", pin_oe, p);
            chk("R2 out", pin_out, p & q);
        end

        // R10 disabled pin neither drives nor flags
        bw(P_DIR, 32'h10); bw(P_OUT, 32'h10);
        bw(P_EN, ~32'h10);
        idle(1);
        chk("R10 oe off", pin_oe, 0);
        chk("R10 out off", pin_out, 0);
        pin_in = 32'h10;
        idle(4);
        br(P_FLAG, v); chk("R10 no flag", v, 0);
        bw(P_EN, 32'hFFFF_FFFF);
        idle(1);
        br(P_FLAG, v); chk("R4 flag after enable", v, 32'h10);
        pin_in = 0; idle(4);
        bw(P_FLAG, 32'hFFFF_FFFF);
        bw(P_DIR, 0);
        bw(P_OUT, 0);

        // R7 R8 ownership-masked writes and reads
        mo = 0;
        for (int k = 0; k < 8; k++) begin
            o = 32'hA5A5_A5A5 ^ (32'h1111_1111 * k);
            p = 32'h1234_5678 * (k + 3);
            q = ~(32'h8765_4321 * (k + 5));
            bw(P_OWN, o);
            bw(P_OUT, p);  mo = (mo & o) | (p & ~o);
            br(P_OUT, v);  chk("R8 priv write", v, mo);
            bw(R_OUT, q);  mo = (mo & ~o) | (q & o);
            br(P_OUT, v);  chk("R8 priv reads all", v, mo);
            br(R_OUT, v);  chk("R7 restr view", v, mo & o);
        end
        bw(P_OWN, 0);
        bw(P_OUT, 0);

        // R9 shared storage
        bw(P_MASK, 32'h0000_003C);
        bw(P_OWN, 32'hFFFF_FFFF);
        br(R_MASK, v); chk("R9 mask visible", v, 32'h3C);
        br(R_LVL, v);  chk("R9 level visible", v, 32'hFFFF_FFFF);
        bw(R_MASK, 0);
        bw(P_OWN, 0);

        // R3 input sampling and read-only registers
        bw(P_OWN, 32'h0000_FFFF);
        for (int k = 0; k < 6; k++) begin
            p = 32'hC3A5_0F1E * (k + 1);
            pin_in = p;
            idle(3);
            br(P_IN, v); chk("R3 in", v, p);
            br(R_IN, v); chk("R3 restr in", v, p & 32'hFFFF);
            bw(P_IN, ~p);
            br(P_IN, v); chk("R3 in write ignored", v, p);
        end
        br(P_SNAP, q);
        bw(P_SNAP, ~q);
        br(P_SNAP, v); chk("R3 snap write ignored", v, q);
        pin_in = 0; idle(4);
        bw(P_OWN, 0);
        bw(P_FLAG, 32'hFFFF_FFFF);
        br(P_FLAG, v); chk("R5 clear idle", v, 0);

        // R4 R5 R11 per-pin sweep
        for (int i = 0; i < 32; i++) begin
            pin_in = 32'h1 << i;
            idle(4);
            br(P_FLAG, v); chk("R4 flag set", v, 32'h1 << i);
            br(P_SNAP, v); chk("R11 snap", v, 32'h1 << i);
            bw(P_FLAG, 32'hFFFF_FFFF);
            br(P_FLAG, v); chk("R5 stuck while active", v, 32'h1 << i);
            pin_in = 0;
            idle(4);
            br(P_FLAG, v); chk("R4 sticky", v, 32'h1 << i);
            bw(P_FLAG, 0);
            br(P_FLAG, v); chk("R5 zero write inert", v, 32'h1 << i);
            bw(P_FLAG, 32'hFFFF_FFFF);
            br(P_FLAG, v); chk("R5 cleared", v, 0);
        end

        // R4 low-level trigger
        bw(P_LVL, ~32'h8);
        idle(1);
        br(P_FLAG, v); chk("R4 low level", v, 32'h8);
        bw(P_LVL, 32'hFFFF_FFFF);
        bw(P_FLAG, 32'hFFFF_FFFF);
        br(P_FLAG, v); chk("R5 clear after invert", v, 0);

        // R6 interrupt routing
        pin_in = 32'h80;
        idle(4);
        chk("R6 unmasked", {31'd0, irq_priv}, 0);
        bw(P_MASK, 32'h80);
        chk("R6 priv irq", {30'd0, irq_priv, irq_restr}, 32'h2);
        bw(P_OWN, 32'h80);
        chk("R6 restr irq", {30'd0, irq_priv, irq_restr}, 32'h1);
        br(R_FLAG, v); chk("R9 flag visible", v, 32'h80);
        bw(P_MASK, 0);
        br(P_MASK, v); chk("R8 owned mask kept", v, 32'h80);
        bw(R_FLAG, 32'hFFFF_FFFF);
        br(R_FLAG, v); chk("R5 restr stuck", v, 32'h80);
        pin_in = 32'h200;
        idle(4);
        bw(R_FLAG, 32'hFFFF_FFFF);
        br(P_FLAG, v); chk("R7 restr clear only owned", v, 32'h200);
        chk("R6 irq low", {30'd0, irq_priv, irq_restr}, 0);

        // R1 undefined offsets
        br(8'h40, v); chk("R1 undefined read", v, 0);
        br(8'hFC, v); chk("R1 high read", v, 0);
        br(8'h21, v); chk("R1 misaligned read", v, 0);
        bw(8'h60, 32'hFFFF_FFFF);
        bw(8'h22, 32'hFFFF_FFFF);
        br(P_OUT, v); chk("R1 stray write", v, 0);
        br(P_OWN, v); chk("R1 owner untouched", v, 32'h80);

        finish_run();
    end
endmodule